// File: doc/BRIEF.md
# Spike-Timing Weight Update Controller

This block works out how much one synapse should change, based on when its input neuron and its output neuron last fired. A free-running 8-bit timestamp counter stamps the first pre-synaptic spike and the first post-synaptic spike of a pairing window. The signed interval between them selects a magnitude from a programmable eight-entry plasticity table. That magnitude is multiplied by a learning rate and given a sign. The result leaves the block as a signed weight delta with a one-cycle valid strobe. A separate weight memory, not part of this block, adds the delta to the stored weight.

A four-state sequencer runs each update. From `ST_IDLE`, an arm command moves it to `ST_CAPTURE`. Once both spikes are held it moves to `ST_COMPUTE`, and the delta is registered. In `ST_APPLY` the delta is committed, or dropped when the gate is in reward mode. After that it returns to `ST_IDLE` with a done flag set (single-shot) or goes straight back to `ST_CAPTURE` (continuous).

The transitions are:
- IDLE→CAPTURE on arm.
- CAPTURE→COMPUTE when a pair is complete.
- COMPUTE→APPLY always.
- APPLY→IDLE or APPLY→CAPTURE on commit or drop.

Three modes change the update:
- Anti-Hebbian mode flips the sign.
- An eligibility trace is loaded when a pair completes and then decays.
- Reward mode holds the commit until a reward input arrives while the trace is still nonzero.

Configuration uses a simple synchronous register write port.

Top module: `stdp_update_unit`

## Requirements
- R1: After reset, `delta_valid` is 0, `delta_out` is 0, `done` is 0, and the sequencer is idle.
- R2: A write to address 0 with bit 0 set arms the sequencer, but only while it is idle. Spikes that arrive while it is idle produce no update.
- R3: In the capture state, only the first pre spike and the first post spike are timestamped. The interval is post minus pre, taken modulo 256 as a signed 8-bit value. Repeated spikes of either kind are ignored.
- R4: The table bin is min(|dt| >> 2, 3). dt ≥ 0 (zero included) reads the potentiation entries at addresses 8..11. dt < 0 reads the depression entries at addresses 12..15. In both cases the address is the half base plus the bin.
- R5: The delta is entry × rate, where the rate is address 1, low 4 bits. The delta is positive for potentiation and negative for depression.
- R6: Control bit 2 (anti-Hebbian) negates the delta.
- R7: `delta_valid` is a single-cycle pulse. In the ungated mode it rises in the second cycle after the clock edge that samples the completing spike. `delta_out` is 0 whenever `delta_valid` is low.
- R8: In single-shot mode (control bit 1 clear), the sequencer returns to idle after apply, and `done` stays 1 until the next arm.
- R9: In continuous mode (control bit 1 set), the sequencer re-arms capture by itself after every apply and does not set `done`.
- R10: In reward mode (control bit 3), apply holds until `reward` is high while the trace is nonzero. It then commits the unscaled base delta.
- R11: A completed pair loads the trace with address 2. The trace then drops by one every (address 3 + 1) cycles and saturates at 0. If the trace is 0 in reward-mode apply, the update is dropped and no strobe appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pre_spike | input | 1 | Pre-synaptic spike event |
| post_spike | input | 1 | Post-synaptic spike event |
| reward | input | 1 | Reward signal for gated mode |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 4 | Configuration address |
| cfg_wdata | input | 8 | Configuration write data |
| delta_valid | output | 1 | Weight delta strobe |
| delta_out | output | 13 | Signed weight delta |
| done | output | 1 | Single-shot update finished |

## Verification
The bench sweeps the interval from -14 to +14 and checks the value and latency of every delta. A design that sent dt = 0 to the depression half, or that chose bins off by one, fails at the bin edges (±3, ±4, ±11, ±12). Separate cases cover:
- intervals past the clamp;
- a repeated pre spike, which a design that re-stamped it would turn into a shorter interval;
- anti-Hebbian inversion;
- continuous re-arming with no new arm write.

The reward cases check three things: a trace that expires drops the update, a late reward commits the unscaled delta for exactly one cycle, and a zero trace load blocks commit even when reward is held high.

// File: rtl/stdp_pkg.sv
package stdp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CAPTURE,
        ST_COMPUTE,
        ST_APPLY
    } state_t;

    // default widths
    localparam int unsigned TS_W_DEF      = 8;
    localparam int unsigned MAG_W_DEF     = 8;
    localparam int unsigned RATE_W_DEF    = 4;
    localparam int unsigned TRACE_W_DEF   = 8;
    localparam int unsigned DATA_W_DEF    = 8;
    localparam int unsigned BIN_SHIFT_DEF = 2;

    // plasticity table: bins per half, two halves
    localparam int unsigned N_BINS  = 4;
    localparam int unsigned TBL_N   = 2 * N_BINS;
    localparam int unsigned TBL_IW  = $clog2(TBL_N);
    localparam int unsigned CFG_AW  = 4;

    // register addresses; addr[3] selects the table, addr[2] the half
    localparam logic [CFG_AW-1:0] A_CTRL       = 4'd0;
    localparam logic [CFG_AW-1:0] A_RATE       = 4'd1;
    localparam logic [CFG_AW-1:0] A_TRACE_INIT = 4'd2;
    localparam logic [CFG_AW-1:0] A_DECAY      = 4'd3;

    // control bit positions
    localparam int unsigned C_ARM  = 0;
    localparam int unsigned C_CONT = 1;
    localparam int unsigned C_ANTI = 2;
    localparam int unsigned C_RWD  = 3;

endpackage

// File: rtl/stdp_cfg_regs.sv
module stdp_cfg_regs
    import stdp_pkg::*;
#(
    parameter int unsigned MAG_W   = MAG_W_DEF,
    parameter int unsigned RATE_W  = RATE_W_DEF,
    parameter int unsigned TRACE_W = TRACE_W_DEF,
    parameter int unsigned DATA_W  = DATA_W_DEF
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          we,
    input  logic [CFG_AW-1:0]             addr,
    input  logic [DATA_W-1:0]             wdata,
    output logic                          arm,
    output logic                          cont_mode,
    output logic                          anti_mode,
    output logic                          rwd_mode,
    output logic [RATE_W-1:0]             rate,
    output logic [TRACE_W-1:0]            trace_init,
    output logic [TRACE_W-1:0]            decay_per,
    output logic [TBL_N-1:0][MAG_W-1:0]   tbl
);

    assign arm = we && (addr == A_CTRL) && wdata[C_ARM];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cont_mode  <= 1'b0;
            anti_mode  <= 1'b0;
            rwd_mode   <= 1'b0;
            rate       <= RATE_W'(1);
            trace_init <= '0;
            decay_per  <= '0;
            tbl        <= '0;
        end else if (we) begin
            if (addr[CFG_AW-1]) begin
                tbl[addr[TBL_IW-1:0]] <= wdata[MAG_W-1:0];
            end else begin
                unique case (addr)
                    A_CTRL: begin
                        cont_mode <= wdata[C_CONT];
                        anti_mode <= wdata[C_ANTI];
                        rwd_mode  <= wdata[C_RWD];
                    end
                    A_RATE:       rate       <= wdata[RATE_W-1:0];
                    A_TRACE_INIT: trace_init <= wdata[TRACE_W-1:0];
                    A_DECAY:      decay_per  <= wdata[TRACE_W-1:0];
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/stdp_delta_calc.sv
module stdp_delta_calc
    import stdp_pkg::*;
#(
    parameter int unsigned TS_W      = TS_W_DEF,
    parameter int unsigned MAG_W     = MAG_W_DEF,
    parameter int unsigned RATE_W    = RATE_W_DEF,
    parameter int unsigned BIN_SHIFT = BIN_SHIFT_DEF
) (
    input  logic [TS_W-1:0]                  pre_ts,
    input  logic [TS_W-1:0]                  post_ts,
    input  logic [TBL_N-1:0][MAG_W-1:0]      tbl,
    input  logic [RATE_W-1:0]                rate,
    input  logic                             anti,
    output logic signed [MAG_W+RATE_W:0]     delta
);

    localparam int unsigned BIN_W = $clog2(N_BINS);
    localparam int unsigned PROD_W = MAG_W + RATE_W;

    logic [TS_W-1:0]   diff, mag, shifted;
    logic              neg;
    logic [BIN_W-1:0]  bin;
    logic [MAG_W-1:0]  entry;
    logic [PROD_W-1:0] prod;
    logic signed [PROD_W:0] mag_s;

    always_comb begin
        diff    = post_ts - pre_ts;          // wraps modulo 2^TS_W
        neg     = diff[TS_W-1];
        mag     = neg ? (~diff + 1'b1) : diff;
        shifted = mag >> BIN_SHIFT;
        bin     = (shifted > TS_W'(N_BINS - 1)) ? BIN_W'(N_BINS - 1)
                                                : shifted[BIN_W-1:0];
        entry   = tbl[{neg, bin}];           // upper half holds depression
        prod    = {{RATE_W{1'b0}}, entry} * {{MAG_W{1'b0}}, rate};
        mag_s   = $signed({1'b0, prod});
        delta   = (neg ^ anti) ? -mag_s : mag_s;
    end

endmodule

// File: rtl/stdp_trace.sv
module stdp_trace #(
    parameter int unsigned TRACE_W = stdp_pkg::TRACE_W_DEF
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [TRACE_W-1:0] init,
    input  logic [TRACE_W-1:0] period,
    output logic [TRACE_W-1:0] trace
);

    logic [TRACE_W-1:0] div_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trace <= '0;
            div_q <= '0;
        end else if (load) begin
            trace <= init;
            div_q <= '0;
        end else if (div_q == period) begin
            div_q <= '0;
            if (trace != '0) trace <= trace - 1'b1;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

endmodule

// File: rtl/stdp_update_unit.sv
module stdp_update_unit
    import stdp_pkg::*;
#(
    parameter int unsigned TS_W      = TS_W_DEF,
    parameter int unsigned MAG_W     = MAG_W_DEF,
    parameter int unsigned RATE_W    = RATE_W_DEF,
    parameter int unsigned TRACE_W   = TRACE_W_DEF,
    parameter int unsigned DATA_W    = DATA_W_DEF,
    parameter int unsigned BIN_SHIFT = BIN_SHIFT_DEF
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          pre_spike,
    input  logic                          post_spike,
    input  logic                          reward,
    input  logic                          cfg_we,
    input  logic [CFG_AW-1:0]             cfg_addr,
    input  logic [DATA_W-1:0]             cfg_wdata,
    output logic                          delta_valid,
    output logic signed [MAG_W+RATE_W:0]  delta_out,
    output logic                          done
);

    localparam int unsigned DELTA_W = MAG_W + RATE_W + 1;

    state_t state_q, state_d;

    logic                         arm, cont_mode, anti_mode, rwd_mode;
    logic [RATE_W-1:0]            rate;
    logic [TRACE_W-1:0]           trace_init, decay_per, trace_q;
    logic [TBL_N-1:0][MAG_W-1:0]  tbl;

    logic [TS_W-1:0]              ts_q, pre_ts_q, post_ts_q;
    logic                         pre_got_q, post_got_q;
    logic signed [DELTA_W-1:0]    calc_delta, delta_q;
    logic                         done_q;
    logic                         pair_done, load_trace, commit, drop;

    stdp_cfg_regs #(
        .MAG_W(MAG_W), .RATE_W(RATE_W), .TRACE_W(TRACE_W), .DATA_W(DATA_W)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
        .arm(arm), .cont_mode(cont_mode), .anti_mode(anti_mode), .rwd_mode(rwd_mode),
        .rate(rate), .trace_init(trace_init), .decay_per(decay_per), .tbl(tbl)
    );

    stdp_delta_calc #(
        .TS_W(TS_W), .MAG_W(MAG_W), .RATE_W(RATE_W), .BIN_SHIFT(BIN_SHIFT)
    ) u_calc (
        .pre_ts(pre_ts_q), .post_ts(post_ts_q), .tbl(tbl), .rate(rate),
        .anti(anti_mode), .delta(calc_delta)
    );

    stdp_trace #(.TRACE_W(TRACE_W)) u_trace (
        .clk(clk), .rst_n(rst_n), .load(load_trace), .init(trace_init),
        .period(decay_per), .trace(trace_q)
    );

    assign pair_done  = (pre_got_q || pre_spike) && (post_got_q || post_spike);
    assign load_trace = (state_q == ST_CAPTURE) && pair_done;
    assign commit     = !rwd_mode || (reward && (trace_q != '0));
    assign drop       = rwd_mode && (trace_q == '0);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (arm) state_d = ST_CAPTURE;
            ST_CAPTURE: if (pair_done) state_d = ST_COMPUTE;
            ST_COMPUTE: state_d = ST_APPLY;
            ST_APPLY:   if (commit || drop) state_d = cont_mode ? ST_CAPTURE : ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // timestamp counter, spike capture, result and done flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ts_q       <= '0;
            pre_ts_q   <= '0;
            post_ts_q  <= '0;
            pre_got_q  <= 1'b0;
            post_got_q <= 1'b0;
            delta_q    <= '0;
            done_q     <= 1'b0;
        end else begin
            ts_q <= ts_q + 1'b1;
            if (state_q != ST_CAPTURE) begin
                pre_got_q  <= 1'b0;
                post_got_q <= 1'b0;
            end else begin
                if (pre_spike && !pre_got_q) begin
                    pre_ts_q  <= ts_q;
                    pre_got_q <= 1'b1;
                end
                if (post_spike && !post_got_q) begin
                    post_ts_q  <= ts_q;
                    post_got_q <= 1'b1;
                end
            end
            if (state_q == ST_COMPUTE) delta_q <= calc_delta;
            if (state_q == ST_IDLE && arm)
                done_q <= 1'b0;
            else if (state_q == ST_APPLY && state_d == ST_IDLE)
                done_q <= 1'b1;
        end
    end

    // outputs
    always_comb begin
        delta_valid = (state_q == ST_APPLY) && commit;
        delta_out   = delta_valid ? delta_q : '0;
        done        = done_q;
    end

endmodule

// File: rtl/stdp_update_checker.sv
module stdp_update_checker
    import stdp_pkg::*;
#(
    parameter int unsigned DELTA_W = MAG_W_DEF + RATE_W_DEF + 1,
    parameter int unsigned TRACE_W = TRACE_W_DEF
) (
    input logic               clk,
    input logic               rst_n,
    input state_t             state_q,
    input logic               delta_valid,
    input logic [DELTA_W-1:0] delta_out,
    input logic               done,
    input logic               reward,
    input logic               rwd_mode,
    input logic [TRACE_W-1:0] trace_q
);

    // R7: strobe lasts one cycle
    a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        delta_valid |=> !delta_valid);

    // R7: output quiet between strobes
    a_r7_quiet_output: assert property (@(posedge clk) disable iff (!rst_n)
        !delta_valid |-> (delta_out == '0));

    // R8: done only while idle
    a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (state_q == ST_IDLE));

    // R10: gated commit needs reward and a live trace
    a_r10_reward_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (rwd_mode && delta_valid) |-> (reward && (trace_q != '0)));

    // R11: trace only rises on a load, which coincides with entering compute
    a_r11_trace_load: assert property (@(posedge clk) disable iff (!rst_n)
        (trace_q > $past(trace_q)) |-> (state_q == ST_COMPUTE));

    // R11: decay steps by exactly one
    a_r11_trace_step: assert property (@(posedge clk) disable iff (!rst_n)
        ((trace_q < $past(trace_q)) && (state_q != ST_COMPUTE))
            |-> (trace_q == $past(trace_q) - 1'b1));

endmodule

bind stdp_update_unit stdp_update_checker #(
    .DELTA_W(MAG_W + RATE_W + 1), .TRACE_W(TRACE_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .state_q(state_q), .delta_valid(delta_valid),
    .delta_out(delta_out), .done(done), .reward(reward), .rwd_mode(rwd_mode),
    .trace_q(trace_q)
);

// File: tb/stdp_update_unit_test.sv
module stdp_update_unit_test;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pre_spike = 1'b0, post_spike = 1'b0, reward = 1'b0;
    logic cfg_we = 1'b0;
    logic [3:0] cfg_addr = '0;
    logic [7:0] cfg_wdata = '0;
    logic delta_valid, done;
    logic signed [12:0] delta_out;

    int checks = 0;
    int errors = 0;
    int pot [4] = '{50, 30, 15, 5};
    int dep [4] = '{40, 25, 12, 4};
    int rate = 3;

    always #5 clk = ~clk;

    stdp_update_unit uut (
        .clk(clk), .rst_n(rst_n), .pre_spike(pre_spike), .post_spike(post_spike),
        .reward(reward), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .delta_valid(delta_valid), .delta_out(delta_out), .done(done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 4'(a); cfg_wdata = 8'(d);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    function automatic int expect_delta(input int dt, input bit anti);
        int mag, bin, e, b;
        mag = (dt < 0) ? -dt : dt;
        bin = mag >> 2;
        if (bin > 3) bin = 3;
        e = (dt < 0) ? dep[bin] : pot[bin];
        b = e * rate;
        return ((dt < 0) ^ anti) ? -b : b;
    endfunction

    task automatic pair(input int dt);
        int span, pre_at, post_at;
        span    = (dt < 0) ? -dt : dt;
        pre_at  = (dt < 0) ? span : 0;
        post_at = (dt < 0) ? 0 : span;
        for (int i = 0; i <= span; i++) begin
            @(negedge clk);
            pre_spike  = (i == pre_at);
            post_spike = (i == post_at);
        end
        @(negedge clk);
        pre_spike = 1'b0; post_spike = 1'b0;
    endtask

    task automatic poll(input int maxc, output bit got, output int val, output int lat);
        got = 0; val = 0; lat = 0;
        for (int i = 1; i <= maxc; i++) begin
            @(negedge clk); #1;
            if (!got && delta_valid) begin
                got = 1; val = int'(delta_out); lat = i;
                break;
            end
        end
    endtask

    task automatic one_update(input int dt, input bit anti, input string req);
        bit got; int val, lat;
        wr(0, anti ? 8'h05 : 8'h01);
        pair(dt);
        poll(6, got, val, lat);
        chk(got && lat == 1, req, lat, 1);
        chk(val == expect_delta(dt, anti), req, val, expect_delta(dt, anti));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        bit got; int val, lat;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        // R1 reset state
        chk(delta_valid == 0, "R1", delta_valid, 0);
        chk(delta_out == 0, "R1", delta_out, 0);
        chk(done == 0, "R1", done, 0);

        wr(1, rate);
        for (int b = 0; b < 4; b++) begin
            wr(8 + b, pot[b]);
            wr(12 + b, dep[b]);
        end

        // R2: spikes while idle do nothing
        pair(2);
        poll(8, got, val, lat);
        chk(!got, "R2", got, 0);
        chk(done == 0, "R2", done, 0);

        // R4 R5 R7 R8: sweep of intervals, single shot
        for (int dt = -14; dt <= 14; dt++) begin
            one_update(dt, 1'b0, "R4_R5_R7");
            @(negedge clk); #1;
            chk(done == 1, "R8", done, 1);
        end

        // R4 clamp beyond last bin
        one_update(40, 1'b0, "R4");
        one_update(-40, 1'b0, "R4");

        // R5 different rate
        rate = 15; wr(1, rate);
        one_update(5, 1'b0, "R5");
        one_update(-1, 1'b0, "R5");
        rate = 3; wr(1, rate);

        // R6 anti-Hebbian
        one_update(3, 1'b1, "R6");
        one_update(-6, 1'b1, "R6");
        one_update(0, 1'b1, "R6");

        // R3: repeated pre spike ignored, dt = 5
        wr(0, 8'h01);
        for (int i = 0; i <= 5; i++) begin
            @(negedge clk);
            pre_spike  = (i == 0) || (i == 2);
            post_spike = (i == 5);
        end
        @(negedge clk); pre_spike = 0; post_spike = 0;
        poll(6, got, val, lat);
        chk(got && val == expect_delta(5, 0), "R3", val, expect_delta(5, 0));

        // R9 continuous re-arm
        wr(0, 8'h03);
        pair(2);
        poll(6, got, val, lat);
        chk(got && val == expect_delta(2, 0), "R9", val, expect_delta(2, 0));
        pair(-9);
        poll(6, got, val, lat);
        chk(got && val == expect_delta(-9, 0), "R9", val, expect_delta(-9, 0));
        chk(done == 0, "R9", done, 0);
        wr(0, 8'h00);
        pair(7);
        poll(6, got, val, lat);
        chk(got && val == expect_delta(7, 0), "R9", val, expect_delta(7, 0));
        @(negedge clk); #1;
        chk(done == 1, "R8", done, 1);

        // R11 trace expires without reward: update dropped
        wr(2, 5); wr(3, 0);
        reward = 1'b0;
        wr(0, 8'h09);
        pair(1);
        poll(15, got, val, lat);
        chk(!got, "R11", got, 0);
        chk(done == 1, "R11", done, 1);

        // R10 late reward within a long trace commits base delta
        wr(2, 200); wr(3, 3);
        wr(0, 8'h09);
        pair(-2);
        poll(10, got, val, lat);
        chk(!got, "R10", got, 0);
        @(negedge clk);
        reward = 1'b1;
        #1;
        chk(delta_valid == 1, "R10", delta_valid, 1);
        chk(int'(delta_out) == expect_delta(-2, 0), "R10", int'(delta_out), expect_delta(-2, 0));
        @(negedge clk);
        reward = 1'b0;
        #1;
        chk(delta_valid == 0, "R10", delta_valid, 0);
        chk(done == 1, "R10", done, 1);

        // R11 zero trace load blocks commit even with reward held
        wr(2, 0);
        reward = 1'b1;
        wr(0, 8'h09);
        pair(4);
        poll(10, got, val, lat);
        chk(!got, "R11", got, 0);
        chk(done == 1, "R11", done, 1);
        reward = 1'b0;

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule